// File: doc/BRIEF.md
# Direct-Mapped Branch Target Cache

This block sits in the fetch stage and produces the address of the next instruction word to fetch. It normally steps forward one 4-byte word per cycle. It also keeps a direct-mapped table of direct branches that have already resolved. When sequential fetch reaches a branch that was taken the last time it ran, the next fetch goes straight to the remembered target. That fetch is marked as a predicted-taken branch, so the decode stages downstream leave it alone.

Later pipeline stages feed the block in two ways. A redirect forces the next fetch address. An update bus reports each resolved direct branch: its word address, its target, and whether it was taken. Each update overwrites the entry its address indexes, and the entry's valid bit records only the latest outcome.

The table read is pipelined over two register stages. Each cycle, the block reads the entry for the word two ahead of the current fetch address. As a result, the first two fetches after any change of flow can never be predicted. A change of flow here means reset, an external redirect, or a prediction of the block's own.

There is no separate valid/ready handshake on the fetch address. The fetch address is a control stream, and `stall_i` is its back-pressure. While the stall is high, the fetch address, the prediction flag and the lookup pipeline all hold their values. A redirect is still accepted during a stall.

Top module: `btc_fetch_steer`

## Requirements
- R1: During and right after reset, `fetch_addr_o` equals the RESET_ADDR parameter, `pred_taken_o` is 0, and every table entry is invalid, so no prediction can occur until an update arrives.
- R2: With no stall, no redirect and no prediction, the fetch address advances by 4 each cycle and `pred_taken_o` is 0.
- R3: A redirect in a cycle loads `redir_addr_i` as the next fetch address with `pred_taken_o` 0. This happens even when a prediction or a stall is due in the same cycle.
- R4: While `stall_i` is 1 and no redirect is present, `fetch_addr_o` and `pred_taken_o` hold their values. A prediction that is pending in the lookup pipeline survives the stall and is taken after release.
- R5: After a taken update for word address W with target T, sequential fetch through byte address 4*W is followed by fetch address T with `pred_taken_o` 1. The fetch after that returns to +4 steps with the flag at 0.
- R6: A not-taken update clears the valid bit of its entry, so fetch through that branch continues sequentially.
- R7: After an external redirect to address A, the fetch of A and the fetch of A+4 are never followed by a predicted target. The fetch of A+8 can be.
- R8: An entry is indexed by fetch address bits 11..2 and holds the address bits above bit 11 as its tag. A fetch address with the same index and a different tag does not hit.
- R9: A prediction counts as a change of flow: after predicting target T, neither T nor T+4 is followed by a prediction.
- R10: A later update to the same index replaces the earlier entry's tag and target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Hold fetch address and lookup pipeline |
| redir_valid_i | input | 1 | External redirect request |
| redir_addr_i | input | ADDR_W | Redirect target byte address |
| upd_valid_i | input | 1 | Resolved-branch update strobe |
| upd_pc_word_i | input | ADDR_W-2 | Word address of the resolved branch |
| upd_target_i | input | ADDR_W | Branch target byte address |
| upd_taken_i | input | 1 | 1 = branch was taken, 0 = not taken |
| fetch_addr_o | output | ADDR_W | Current fetch byte address |
| pred_taken_o | output | 1 | Current fetch was produced by a table prediction |

## Verification
A corrupted valid bit or tag shows up at the ports within one cycle of the branch fetch. The cycle after the branch address appears, the output either jumps when it should step by 4, or steps when it should jump. A wrong stage-flush or stage-advance decision in the lookup pipeline shows up differently. It appears as a prediction on the first or second fetch after a redirect or a stall release, or as a lost prediction on the third, which the directed sequences pin down cycle by cycle. A bad target field shows up as a wrong address on the cycle when `pred_taken_o` rises.

// File: rtl/btc_pkg.sv
package btc_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned LOOKAHEAD_WORDS = 2;

  typedef enum logic [1:0] {
    SEL_HOLD,
    SEL_SEQ,
    SEL_PRED,
    SEL_REDIR
  } next_sel_e;
endpackage

// File: rtl/btc_store.sv
module btc_store #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned TAG_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [ADDR_W-1:0] rd_tgt_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_tgt_i,
  input  logic              wr_taken_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem [DEPTH];
  logic [ADDR_W-1:0] tgt_mem [DEPTH];

  // valid bits are the only reset state
  always_ff @(posedge clk_i) begin
    if (rst_i) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= wr_taken_i;
  end

  // tag and target rewritten on every outcome
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_mem[wr_idx_i] <= wr_tag_i;
      tgt_mem[wr_idx_i] <= wr_tgt_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_valid_o <= 1'b0;
    else if (rd_en_i) rd_valid_o <= valid_q[rd_idx_i];
  end

  always_ff @(posedge clk_i) begin
    if (rd_en_i) begin
      rd_tag_o <= tag_mem[rd_idx_i];
      rd_tgt_o <= tgt_mem[rd_idx_i];
    end
  end
endmodule

// File: rtl/btc_lookup.sv
module btc_lookup #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TAG_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              adv_i,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  input  logic              rd_valid_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [ADDR_W-1:0] rd_tgt_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] tgt_o
);
  logic             s1_ok_q;
  logic [TAG_W-1:0] s1_tag_q;
  logic             s1_hit;

  // stage 1: read data paired with the tag it was fetched for
  assign s1_hit = s1_ok_q && rd_valid_i && (rd_tag_i == s1_tag_q);

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) begin
      s1_ok_q <= 1'b0;
      hit_o   <= 1'b0;
    end else if (adv_i) begin
      s1_ok_q <= 1'b1;
      hit_o   <= s1_hit;
    end
  end

  always_ff @(posedge clk_i) begin
    if (adv_i) begin
      s1_tag_q <= look_tag_i;
      tgt_o    <= rd_tgt_i;
    end
  end

  // R7
  flush_kill_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |=> !hit_o);
endmodule

// File: rtl/btc_fetch_steer.sv
module btc_fetch_steer #(
  parameter int unsigned      ADDR_W     = 32,
  parameter int unsigned      IDX_W      = 10,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_0100
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              stall_i,
  input  logic              redir_valid_i,
  input  logic [ADDR_W-1:0] redir_addr_i,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-3:0] upd_pc_word_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic              upd_taken_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              pred_taken_o
);
  import btc_pkg::*;

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned TAG_W  = WORD_W - IDX_W;

  logic [ADDR_W-1:0] pc_q;
  logic              pred_q;
  logic [WORD_W-1:0] look_word;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_tgt;
  logic              hit;
  logic [ADDR_W-1:0] hit_tgt;
  logic              adv;
  logic              flush;
  next_sel_e         sel;

  assign look_word = pc_q[ADDR_W-1:2] + WORD_W'(LOOKAHEAD_WORDS);
  assign adv       = !stall_i;

  always_comb begin
    if (redir_valid_i) sel = SEL_REDIR;
    else if (stall_i)  sel = SEL_HOLD;
    else if (hit)      sel = SEL_PRED;
    else               sel = SEL_SEQ;
  end

  assign flush = (sel == SEL_REDIR) || (sel == SEL_PRED);

  btc_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rd_en_i    (adv),
    .rd_idx_i   (look_word[IDX_W-1:0]),
    .rd_valid_o (rd_valid),
    .rd_tag_o   (rd_tag),
    .rd_tgt_o   (rd_tgt),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_pc_word_i[IDX_W-1:0]),
    .wr_tag_i   (upd_pc_word_i[WORD_W-1:IDX_W]),
    .wr_tgt_i   (upd_target_i),
    .wr_taken_i (upd_taken_i)
  );

  btc_lookup #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_lookup (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .adv_i      (adv),
    .flush_i    (flush),
    .look_tag_i (look_word[WORD_W-1:IDX_W]),
    .rd_valid_i (rd_valid),
    .rd_tag_i   (rd_tag),
    .rd_tgt_i   (rd_tgt),
    .hit_o      (hit),
    .tgt_o      (hit_tgt)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pc_q   <= RESET_ADDR;
      pred_q <= 1'b0;
    end else begin
      unique case (sel)
        SEL_REDIR: begin pc_q <= redir_addr_i; pred_q <= 1'b0; end
        SEL_PRED:  begin pc_q <= hit_tgt;      pred_q <= 1'b1; end
        SEL_SEQ:   begin pc_q <= pc_q + ADDR_W'(WORD_BYTES); pred_q <= 1'b0; end
        default:   begin pc_q <= pc_q;         pred_q <= pred_q; end
      endcase
    end
  end

  assign fetch_addr_o = pc_q;
  assign pred_taken_o = pred_q;

  // R3
  redir_prio_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    redir_valid_i |=> (fetch_addr_o == $past(redir_addr_i)) && !pred_taken_o);

  // R4
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (stall_i && !redir_valid_i) |=> $stable(fetch_addr_o) && $stable(pred_taken_o));

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!stall_i && !redir_valid_i && !hit) |=>
      (fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(WORD_BYTES)) && !pred_taken_o);

  // R5
  pred_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (pred_taken_o && !$past(stall_i)) |-> ($past(hit) && !$past(redir_valid_i)));
endmodule

// File: tb/tb_btc_fetch_steer.sv
module tb_btc_fetch_steer;
  localparam int unsigned AW = 32;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst;
  logic        stall;
  logic        redir_valid;
  logic [31:0] redir_addr;
  logic        upd_valid;
  logic [29:0] upd_pc_word;
  logic [31:0] upd_target;
  logic        upd_taken;
  logic [31:0] fetch_addr;
  logic        pred_taken;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  btc_fetch_steer #(.ADDR_W(AW), .IDX_W(10), .RESET_ADDR(RST_PC)) dut (
    .clk_i         (clk),
    .rst_i         (rst),
    .stall_i       (stall),
    .redir_valid_i (redir_valid),
    .redir_addr_i  (redir_addr),
    .upd_valid_i   (upd_valid),
    .upd_pc_word_i (upd_pc_word),
    .upd_target_i  (upd_target),
    .upd_taken_i   (upd_taken),
    .fetch_addr_o  (fetch_addr),
    .pred_taken_o  (pred_taken)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_fetch(string req, logic [31:0] ea, logic ep);
    checks++;
    if (fetch_addr !== ea || pred_taken !== ep) begin
      errors++;
      $display("FAIL %s: fetch=%h pred=%b expected fetch=%h pred=%b",
               req, fetch_addr, pred_taken, ea, ep);
    end
  endtask

  task automatic follow(string req, logic [31:0] ea, logic ep);
    check_fetch(req, ea, ep);
    tick();
  endtask

  task automatic update(logic [31:0] pc, logic [31:0] tgt, logic taken);
    upd_valid   = 1'b1;
    upd_pc_word = pc[31:2];
    upd_target  = tgt;
    upd_taken   = taken;
    tick();
    upd_valid   = 1'b0;
  endtask

  task automatic redirect(logic [31:0] addr);
    redir_valid = 1'b1;
    redir_addr  = addr;
    stall       = 1'b0;
    tick();
    redir_valid = 1'b0;
  endtask

  localparam logic [31:0] BR  = 32'h1000_0100;
  localparam logic [31:0] TG  = 32'h2000_0000;

  task automatic t_reset();
    follow("R1", RST_PC, 1'b0);
    follow("R2", RST_PC + 4, 1'b0);
    follow("R2", RST_PC + 8, 1'b0);
    check_fetch("R2", RST_PC + 12, 1'b0);
  endtask

  task automatic t_taken();
    stall = 1'b1;
    update(BR, TG, 1'b1);
    redirect(BR - 8);
    follow("R5", BR - 8, 1'b0);
    follow("R5", BR - 4, 1'b0);
    follow("R5", BR, 1'b0);
    follow("R5", TG, 1'b1);
    check_fetch("R5", TG + 4, 1'b0);
  endtask

  task automatic t_prio();
    stall = 1'b1;
    redirect(BR - 8);
    follow("R3", BR - 8, 1'b0);
    follow("R3", BR - 4, 1'b0);
    check_fetch("R3", BR, 1'b0);
    redirect(32'h0000_7000);
    follow("R3", 32'h0000_7000, 1'b0);
    check_fetch("R3", 32'h0000_7004, 1'b0);
  endtask

  task automatic t_stall();
    redirect(BR - 8);
    follow("R4", BR - 8, 1'b0);
    stall = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check_fetch("R4", BR - 4, 1'b0);
      tick();
    end
    stall = 1'b0;
    follow("R4", BR - 4, 1'b0);
    follow("R4", BR, 1'b0);
    check_fetch("R4", TG, 1'b1);
    stall = 1'b1;
    tick();
    check_fetch("R4", TG, 1'b1);
    redirect(32'h0000_2000);
    check_fetch("R3", 32'h0000_2000, 1'b0);
  endtask

  task automatic t_not_taken();
    stall = 1'b1;
    update(BR, TG, 1'b0);
    redirect(BR - 8);
    follow("R6", BR - 8, 1'b0);
    follow("R6", BR - 4, 1'b0);
    follow("R6", BR, 1'b0);
    check_fetch("R6", BR + 4, 1'b0);
  endtask

  task automatic t_early();
    logic [31:0] ra, t3;
    ra = 32'h0000_1200;
    t3 = 32'h0000_4000;
    stall = 1'b1;
    update(ra,     32'h0000_A000, 1'b1);
    update(ra + 4, 32'h0000_B000, 1'b1);
    update(ra + 8, t3,            1'b1);
    update(t3,     32'h0000_C000, 1'b1);
    update(t3 + 4, 32'h0000_D000, 1'b1);
    redirect(ra);
    follow("R7", ra, 1'b0);
    follow("R7", ra + 4, 1'b0);
    follow("R7", ra + 8, 1'b0);
    follow("R7", t3, 1'b1);
    follow("R9", t3 + 4, 1'b0);
    follow("R9", t3 + 8, 1'b0);
    check_fetch("R9", t3 + 12, 1'b0);
  endtask

  task automatic t_tag();
    logic [31:0] p, q;
    p = 32'h0001_2300;
    q = 32'h0002_2300;
    stall = 1'b1;
    update(p, 32'h0000_5000, 1'b1);
    redirect(q - 8);
    follow("R8", q - 8, 1'b0);
    follow("R8", q - 4, 1'b0);
    follow("R8", q, 1'b0);
    check_fetch("R8", q + 4, 1'b0);
    redirect(p - 8);
    follow("R8", p - 8, 1'b0);
    follow("R8", p - 4, 1'b0);
    follow("R8", p, 1'b0);
    check_fetch("R8", 32'h0000_5000, 1'b1);
  endtask

  task automatic t_overwrite();
    logic [31:0] b2;
    b2 = BR + 32'h0000_1000;
    stall = 1'b1;
    update(BR, TG, 1'b1);
    update(b2, 32'h0000_3000, 1'b1);
    redirect(BR - 8);
    follow("R10", BR - 8, 1'b0);
    follow("R10", BR - 4, 1'b0);
    follow("R10", BR, 1'b0);
    check_fetch("R10", BR + 4, 1'b0);
    redirect(b2 - 8);
    follow("R10", b2 - 8, 1'b0);
    follow("R10", b2 - 4, 1'b0);
    follow("R10", b2, 1'b0);
    check_fetch("R10", 32'h0000_3000, 1'b1);
  endtask

  initial begin
    rst = 1'b1;
    stall = 1'b0;
    redir_valid = 1'b0;
    redir_addr = '0;
    upd_valid = 1'b0;
    upd_pc_word = '0;
    upd_target = '0;
    upd_taken = 1'b0;
    repeat (3) tick();
    check_fetch("R1", RST_PC, 1'b0);
    rst = 1'b0;
    t_reset();
    t_taken();
    t_prio();
    t_stall();
    t_not_taken();
    t_early();
    t_tag();
    t_overwrite();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule